// File: doc/BRIEF.md
# Three-Source Interrupt Status Controller

The block collects three interrupt requests into one active-high, level interrupt line toward a host. The three requests are a device request, a controller request and a transmit-queue-empty event. Each request passes through a two-stage synchronizer. It is then inverted or passed straight according to its polarity bit, and it is sensed either as a level or as an inactive-to-active transition according to its sense bit. A detected request sets a sticky status bit.

Software reads and writes four small registers through one shared address. Status bits are cleared by writing ones to them. A mask register selects which pending bits may drive the interrupt line. When no masked bit is pending, the line stays low, so a host that shares the line can tell that this block did not raise it. All configuration resets to zero: level sensing, active-high inputs, everything masked.

Top module: `isc_top`

## Requirements
- R1: During and after reset, the status, mask, sense and polarity registers read zero and `irq_o` is low.
- R2: A change on a request input reaches the status register on the third rising clock edge after it is applied. After two edges the status is still unchanged.
- R3: A polarity bit of 1 makes its request active low. A polarity bit of 0 makes it active high.
- R4: A sense bit of 1 sets the status bit only on an inactive-to-active transition of the synchronized, polarity-corrected request. A sense bit of 0 sets it in every cycle that the request is active.
- R5: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A status bit stays set after its request goes away.
- R6: Clearing a level-sensed bit while its request is still active leaves the bit set.
- R7: When a detected transition and a clear of the same bit fall on the same edge, the bit ends up set.
- R8: `irq_o` is high exactly when some status bit is set and its mask bit is 1. Changing the mask never changes the status.
- R9: Register addresses are status = 0, mask = 1, sense = 2 and polarity = 3. Bit positions in every register are device = 2, controller = 1 and queue-empty = 0. Mask, sense and polarity read back as written. Writing zero to all three returns the block to its disabled default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (3) | Asynchronous request inputs (bit 2 device, bit 1 controller, bit 0 queue-empty) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wr_data_i | input | NSRC (3) | Write data |
| rd_data_o | output | NSRC (3) | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The two functions that can fall in the same cycle are setting a status bit and clearing it through a write. The bench provokes this twice. For a level-sensed bit, it writes a clear while the request is still held. For a transition-sensed bit, it places the clear write on exactly the third edge after the request rises, which is the edge where the synchronized transition sets the bit. In both cases the bit must read back as set and the interrupt line must stay high. A later clear, with no new transition, must then empty the bit.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned ISC_AW = 2;

  localparam logic [ISC_AW-1:0] REG_STAT = 2'd0;
  localparam logic [ISC_AW-1:0] REG_MASK = 2'd1;
  localparam logic [ISC_AW-1:0] REG_SENS = 2'd2;
  localparam logic [ISC_AW-1:0] REG_POL  = 2'd3;

  localparam int unsigned SRC_QEMPTY = 0;
  localparam int unsigned SRC_CTRL   = 1;
  localparam int unsigned SRC_DEV    = 2;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/isc_detect.sv
module isc_detect #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] sens_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] act;
  logic [W-1:0] act_q;

  assign act = lvl_i ^ pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_src
      always_comb begin
        if (sens_i[g]) set_o[g] = act[g] & ~act_q[g];
        else           set_o[g] = act[g];
      end
    end
  endgenerate
endmodule

// File: rtl/isc_stat.sv
module isc_stat #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int unsigned NSRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ISC_AW-1:0] addr_i,
  input  logic [NSRC-1:0]   wr_data_i,
  output logic [NSRC-1:0]   rd_data_o,
  output logic              irq_o
);
  logic [NSRC-1:0] src_s;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] sens_q, sens_d;
  logic [NSRC-1:0] pol_q,  pol_d;
  logic            we_stat, we_mask, we_sens, we_pol;

  isc_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  isc_detect #(.W(NSRC)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_s),
    .pol_i  (pol_q),
    .sens_i (sens_q),
    .set_o  (set_vec)
  );

  isc_stat #(.W(NSRC)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .stat_o (status)
  );

  always_comb begin
    we_stat = wr_en_i && (addr_i == REG_STAT);
    we_mask = wr_en_i && (addr_i == REG_MASK);
    we_sens = wr_en_i && (addr_i == REG_SENS);
    we_pol  = wr_en_i && (addr_i == REG_POL);
    clr_vec = we_stat ? wr_data_i : '0;
    mask_d  = we_mask ? wr_data_i : mask_q;
    sens_d  = we_sens ? wr_data_i : sens_q;
    pol_d   = we_pol  ? wr_data_i : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sens_q <= '0;
      pol_q  <= '0;
    end else begin
      mask_q <= mask_d;
      sens_q <= sens_d;
      pol_q  <= pol_d;
    end
  end

  always_comb begin
    case (addr_i)
      REG_STAT: rd_data_o = status;
      REG_MASK: rd_data_o = mask_q;
      REG_SENS: rd_data_o = sens_q;
      default:  rd_data_o = pol_q;
    endcase
  end

  assign irq_o = |(status & mask_q);
endmodule

// File: rtl/isc_chk.sv
module isc_chk
  import isc_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ISC_AW-1:0] addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      set_vec,
  input logic [W-1:0]      status,
  input logic [W-1:0]      mask,
  input logic              irq
);
  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> !irq); // R1

  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(set_vec)) == '0); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_STAT) |=> ((status & $past(wr_data & ~set_vec)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!$stable(status) || !$stable(mask))); // R8

  AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8
endmodule

bind isc_top isc_chk #(.W(NSRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en_i),
  .addr    (addr_i),
  .wr_data (wr_data_i),
  .set_vec (set_vec),
  .status  (status),
  .mask    (mask_q),
  .irq     (irq_o)
);

// File: tb/isc_top_tb_top.sv
module isc_top_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NV = 7;

  // {pol, sense, mask, src_before, src_after, expected_status}
  localparam logic [17:0] VEC [NV] = '{
    {3'b000, 3'b000, 3'b111, 3'b000, 3'b101, 3'b101},
    {3'b111, 3'b000, 3'b111, 3'b111, 3'b010, 3'b101},
    {3'b000, 3'b111, 3'b111, 3'b000, 3'b011, 3'b011},
    {3'b000, 3'b111, 3'b111, 3'b011, 3'b011, 3'b000},
    {3'b010, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010},
    {3'b000, 3'b100, 3'b100, 3'b100, 3'b000, 3'b000},
    {3'b100, 3'b100, 3'b111, 3'b100, 3'b000, 3'b100}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] src_i;
  logic       wr_en_i;
  logic [1:0] addr_i;
  logic [2:0] wr_data_i;
  logic [2:0] rd_data_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  isc_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [2:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] r;
    rst_n = 1'b0; src_i = '0; wr_en_i = 1'b0; addr_i = '0; wr_data_i = '0;
    repeat (3) tick();
    chk("R1 irq in reset", irq_o, 1'b0);
    rst_n = 1'b1;
    tick();
    rd(2'd0, r); chk("R1 status", r, 3'b000);
    rd(2'd1, r); chk("R1 mask", r, 3'b000);
    rd(2'd2, r); chk("R1 sense", r, 3'b000);
    rd(2'd3, r); chk("R1 polarity", r, 3'b000);
    chk("R1 irq", irq_o, 1'b0);

    // Table walk: R3 polarity, R4 sensing, R8 masking
    for (int v = 0; v < NV; v++) begin
      wr(2'd3, VEC[v][17:15]);
      wr(2'd2, VEC[v][14:12]);
      wr(2'd1, VEC[v][11:9]);
      src_i = VEC[v][8:6];
      repeat (4) tick();
      wr(2'd0, 3'b111);
      tick();
      src_i = VEC[v][5:3];
      repeat (4) tick();
      rd(2'd0, r);
      chk("R3/R4 table status", r, VEC[v][2:0]);
      chk("R8 table irq", irq_o, |(VEC[v][2:0] & VEC[v][11:9]));
    end

    // R2 latency, level-sensed bit 0
    wr(2'd3, 3'b000); wr(2'd2, 3'b000); wr(2'd1, 3'b001);
    src_i = 3'b000; repeat (4) tick(); wr(2'd0, 3'b111); tick();
    src_i = 3'b001;
    tick(); tick();
    rd(2'd0, r); chk("R2 after two edges", r, 3'b000);
    tick();
    rd(2'd0, r); chk("R2 after three edges", r, 3'b001);
    chk("R2 irq", irq_o, 1'b1);

    // R6 clear while level still held
    wr(2'd0, 3'b001);
    rd(2'd0, r); chk("R6 re-set on held level", r, 3'b001);
    chk("R6 irq stays", irq_o, 1'b1);

    // R5 sticky and write-one-to-clear
    src_i = 3'b000; repeat (4) tick();
    rd(2'd0, r); chk("R5 sticky after release", r, 3'b001);
    wr(2'd0, 3'b110);
    rd(2'd0, r); chk("R5 zero bits untouched", r, 3'b001);
    wr(2'd0, 3'b001);
    rd(2'd0, r); chk("R5 cleared", r, 3'b000);
    chk("R5 irq low", irq_o, 1'b0);

    // R7 transition and clear on the same edge, bit 1
    wr(2'd2, 3'b010); wr(2'd1, 3'b010);
    src_i = 3'b000; repeat (4) tick(); wr(2'd0, 3'b111); tick();
    src_i = 3'b010;
    tick(); tick();
    wr_en_i = 1'b1; addr_i = 2'd0; wr_data_i = 3'b010;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
    rd(2'd0, r); chk("R7 set wins over clear", r, 3'b010);
    chk("R7 irq", irq_o, 1'b1);
    wr(2'd0, 3'b010);
    rd(2'd0, r); chk("R4 no new transition after clear", r, 3'b000);
    chk("R4 irq low", irq_o, 1'b0);

    // R8 mask gates output only
    wr(2'd2, 3'b000); wr(2'd1, 3'b000);
    src_i = 3'b100; repeat (4) tick();
    rd(2'd0, r); chk("R8 pending while masked", r, 3'b110);
    chk("R8 masked irq", irq_o, 1'b0);
    wr(2'd1, 3'b100);
    chk("R8 unmasked irq", irq_o, 1'b1);
    wr(2'd1, 3'b000);
    chk("R8 remasked irq", irq_o, 1'b0);
    rd(2'd0, r); chk("R8 status untouched by mask", r, 3'b110);

    // R9 register map readback and disabled default
    wr(2'd1, 3'b011); wr(2'd2, 3'b101); wr(2'd3, 3'b110);
    rd(2'd1, r); chk("R9 mask readback", r, 3'b011);
    rd(2'd2, r); chk("R9 sense readback", r, 3'b101);
    rd(2'd3, r); chk("R9 polarity readback", r, 3'b110);
    wr(2'd1, 3'b000); wr(2'd2, 3'b000); wr(2'd3, 3'b000);
    src_i = 3'b000; repeat (4) tick(); wr(2'd0, 3'b111); repeat (2) tick();
    rd(2'd0, r); chk("R9 disabled status", r, 3'b000);
    chk("R9 disabled irq", irq_o, 1'b0);

    finish_run();
  end
endmodule